// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Flags

This block holds the three alarm bytes of a real-time clock (seconds, minutes, hours) and compares them with the current time whenever the time counter reports a finished once-per-second update. It also keeps the interrupt status byte for three sources: the alarm, the periodic tick and the end of an update. From that byte it drives a single level interrupt request. Time counting and prescaling happen in a neighbouring block. This block only sees their results, as time bytes and two single-cycle pulses.

An alarm byte acts as a wildcard when its two top bits are both 1. The hours byte is otherwise compared on all eight bits, so in 12-hour mode the PM bit (bit 7) must agree. The host reads the status byte through `flag_q` and pulses `flag_rd` in the cycle it samples it. That read empties the byte one clock later.

Top module: `rtc_alarm_irq`

## Requirements
- R1: An alarm byte whose bits [7:6] are 2'b11 matches every value of its time field. An alarm made of three such bytes therefore matches at every accepted update.
- R2: Any alarm byte that is not a wildcard matches only an identical time byte, all 8 bits compared. An hours alarm of 0x82 does not match 0x02, and 0x02 does not match 0x82.
- R3: An accepted update where all three fields match sets the alarm flag, `flag_q` bit 5, one clock after the pulse. The flag then stays set until a read.
- R4: Every accepted update sets the update-ended flag, `flag_q` bit 4, one clock after the pulse.
- R5: A `per_tick` pulse sets the periodic flag, `flag_q` bit 6, one clock after the pulse.
- R6: In the cycle where `flag_rd` is high, `flag_q` still shows the current flags. One clock later, every flag is cleared except those raised by an event in that same cycle, so a second read with no new event returns 0x00.
- R7: `flag_q` bit 7 is 1 exactly when some flag in bits 6..4 is set and its enable is high. The enables are `irq_en` bit 2 for periodic, bit 1 for alarm and bit 0 for update, and bit 7 uses their values from the previous clock. `irq` equals `flag_q` bit 7. A flag whose enable is low is still set.
- R8: An `upd_done` pulse while `set_hold` is high is ignored. It sets neither the alarm flag nor the update-ended flag.
- R9: A write with `alm_wr_en` stores `alm_wr_data` into the seconds alarm (`alm_wr_sel` = 0), the minutes alarm (1) or the hours alarm (2). Select value 3 changes nothing.
- R10: After reset, `flag_q` is 0x00, `irq` is 0, and all three alarm bytes are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alm_wr_en | input | 1 | Alarm byte write strobe |
| alm_wr_sel | input | 2 | Alarm byte select: 0 seconds, 1 minutes, 2 hours |
| alm_wr_data | input | 8 | Alarm byte write value |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte, bit 7 = PM in 12-hour mode |
| upd_done | input | 1 | One-cycle pulse when a time update has finished |
| per_tick | input | 1 | One-cycle pulse per elapsed periodic interval |
| set_hold | input | 1 | Host is setting the time; updates are ignored |
| irq_en | input | 3 | Interrupt enables {periodic, alarm, update} |
| flag_rd | input | 1 | Host read strobe for the status byte |
| flag_q | output | 8 | Status byte: 7 request, 6 periodic, 5 alarm, 4 update |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets several specific faults:
- Hours alarms that differ from the time only in the PM bit, in both directions. A comparator that masks bit 7 would raise a false alarm here.
- Wildcard bytes whose lower bits differ from the time. A design that tests only one of the two top bits, or compares the whole byte, would either match too much or miss.
- A read issued in the same cycle as a new event. A design that clears unconditionally would lose that event.
- Updates that arrive while the hold input is high, and enables that toggle while flags are pending. Either would expose a request bit that ignores its enables or counts a blocked update.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_FIELDS = 3;
    localparam int SEL_W    = 2;

    localparam int FLAG_REQ = 7;
    localparam int FLAG_PER = 6;
    localparam int FLAG_ALM = 5;
    localparam int FLAG_UPD = 4;

    // interrupt sources, ordered to line up with status bits 6..4
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs #(
    parameter int DW = 8,
    parameter int NF = 3,
    parameter int SW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SW-1:0]         wr_sel,
    input  logic [DW-1:0]         wr_data,
    output logic [NF-1:0][DW-1:0] alm_o
);
    typedef struct packed {
        logic [NF-1:0][DW-1:0] bytes;
    } alm_st_t;

    alm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NF; i++) begin
            if (wr_en && (wr_sel == SW'(i))) begin
                st_d.bytes[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alm_o = st_q.bytes;

    // R9: a select outside the field range leaves every byte untouched
    p_bad_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_sel) >= NF)) |=> $stable(st_q));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int DW = 8,
    parameter int NF = 3
) (
    input  logic [NF-1:0][DW-1:0] alm_i,
    input  logic [NF-1:0][DW-1:0] cur_i,
    output logic                  hit_o
);
    logic [NF-1:0] field_hit;

    for (genvar g = 0; g < NF; g++) begin : g_field
        logic any_val;
        assign any_val      = (alm_i[g][DW-1:DW-2] == 2'b11);
        assign field_hit[g] = any_val || (alm_i[g] == cur_i[g]);
    end

    assign hit_o = &field_hit;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_t       evt_i,
    input  src_t       en_i,
    input  logic       rd_i,
    output logic [7:0] flags_o
);
    typedef struct packed {
        logic req;
        src_t src;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) st_d.src = evt_i;
        else      st_d.src = st_q.src | evt_i;
        st_d.req = |(st_d.src & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = {st_q, 4'b0000};

    // R6: a read with no new event leaves an empty byte
    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (evt_i == '0)) |=> (flags_o == 8'h00));
    // R6: an event in the read cycle survives the clear
    p_read_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && evt_i.per) |=> flags_o[FLAG_PER]);
    // R3: alarm flag stays set until read
    p_alm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FLAG_ALM] && !rd_i) |=> flags_o[FLAG_ALM]);
    // R5: periodic event sets its flag
    p_per_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.per |=> flags_o[FLAG_PER]);
    // R7: request bit follows enabled flags
    p_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLAG_REQ] == |(flags_o[FLAG_PER:FLAG_UPD] & $past(en_i)));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alm_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alm_wr_en,
    input  logic [SEL_W-1:0] alm_wr_sel,
    input  logic [DW-1:0]    alm_wr_data,
    input  logic [DW-1:0]    cur_sec,
    input  logic [DW-1:0]    cur_min,
    input  logic [DW-1:0]    cur_hour,
    input  logic             upd_done,
    input  logic             per_tick,
    input  logic             set_hold,
    input  logic [2:0]       irq_en,
    input  logic             flag_rd,
    output logic [7:0]       flag_q,
    output logic             irq
);
    localparam int NF = N_FIELDS;

    logic [NF-1:0][DW-1:0] alm_bytes;
    logic [NF-1:0][DW-1:0] cur_bytes;
    logic                  all_hit;
    src_t                  evt, en;

    assign cur_bytes = {cur_hour, cur_min, cur_sec};

    rtc_alarm_regs #(.DW(DW), .NF(NF), .SW(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alm_wr_en),
        .wr_sel  (alm_wr_sel),
        .wr_data (alm_wr_data),
        .alm_o   (alm_bytes)
    );

    rtc_alarm_match #(.DW(DW), .NF(NF)) u_match (
        .alm_i (alm_bytes),
        .cur_i (cur_bytes),
        .hit_o (all_hit)
    );

    always_comb begin
        evt.upd = upd_done && !set_hold;
        evt.alm = evt.upd && all_hit;
        evt.per = per_tick;
        en      = irq_en;
    end

    rtc_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .en_i    (en),
        .rd_i    (flag_rd),
        .flags_o (flag_q)
    );

    assign irq = flag_q[FLAG_REQ];

    // R1: three wildcard bytes match any accepted update
    p_wild_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !set_hold && (alm_bytes[0][DW-1:DW-2] == 2'b11) &&
         (alm_bytes[1][DW-1:DW-2] == 2'b11) && (alm_bytes[2][DW-1:DW-2] == 2'b11))
        |=> flag_q[FLAG_ALM]);
    // R8: held updates leave alarm and update flags as they were
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && !flag_rd) |=> $stable(flag_q[FLAG_ALM:FLAG_UPD]));
    // R4: accepted update raises update-ended flag
    p_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !set_hold) |=> flag_q[FLAG_UPD]);
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alm_wr_en = 1'b0;
    logic [1:0] alm_wr_sel = 2'd0;
    logic [7:0] alm_wr_data = 8'h00;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic       upd_done = 1'b0, per_tick = 1'b0, set_hold = 1'b0, flag_rd = 1'b0;
    logic [2:0] irq_en = 3'b000;
    logic [7:0] flag_q;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_alm [3];
    logic [7:0] m_flags;

    always #5 clk = ~clk;

    rtc_alarm_irq dut_i (
        .clk(clk), .rst_n(rst_n), .alm_wr_en(alm_wr_en), .alm_wr_sel(alm_wr_sel),
        .alm_wr_data(alm_wr_data), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .upd_done(upd_done), .per_tick(per_tick),
        .set_hold(set_hold), .irq_en(irq_en), .flag_rd(flag_rd),
        .flag_q(flag_q), .irq(irq)
    );

    function automatic bit fmatch(input logic [7:0] a, input logic [7:0] c);
        return (a[7:6] == 2'b11) || (a == c);
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // called just after a falling edge; drives one cycle, checks after the next rise
    task automatic step(input bit upd, input bit per, input bit rd, input bit hold,
                        input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input string req);
        logic [2:0] ev, src;
        cur_sec = s; cur_min = m; cur_hour = h;
        upd_done = upd; per_tick = per; flag_rd = rd; set_hold = hold;
        ev[0] = upd && !hold;
        ev[1] = ev[0] && fmatch(m_alm[0], s) && fmatch(m_alm[1], m) && fmatch(m_alm[2], h);
        ev[2] = per;
        src = rd ? ev : (m_flags[6:4] | ev);
        m_flags = {|(src & irq_en), src, 4'b0000};
        @(posedge clk);
        @(negedge clk);
        upd_done = 1'b0; per_tick = 1'b0; flag_rd = 1'b0; set_hold = 1'b0; alm_wr_en = 1'b0;
        check(flag_q, m_flags, req);
        check({7'd0, irq}, {7'd0, m_flags[7]}, {req, " irq R7"});
    endtask

    task automatic wr_alarm(input logic [1:0] sel, input logic [7:0] d);
        alm_wr_en = 1'b1; alm_wr_sel = sel; alm_wr_data = d;
        step(0, 0, 0, 0, cur_sec, cur_min, cur_hour, "R9 write");
        if (sel != 2'd3) m_alm[sel] = d;
    endtask

    task automatic rd_flags(input string req);
        step(0, 0, 1, 0, cur_sec, cur_min, cur_hour, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 3; i++) m_alm[i] = 8'h00;
        m_flags = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(flag_q, 8'h00, "R10 reset flags");
        check({7'd0, irq}, 8'h00, "R10 reset irq");
        // R10: alarm bytes reset to zero, so time 00:00:00 matches
        step(1, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R10 reset alarm zero");
        check(flag_q, 8'h30, "R10 alarm 00 match");
        rd_flags("R6 read clears");
        rd_flags("R6 second read zero");
        check(flag_q, 8'h00, "R6 second read");

        // R9 writes, R2 PM bit mismatch
        wr_alarm(2'd0, 8'h30);
        wr_alarm(2'd1, 8'h15);
        wr_alarm(2'd2, 8'h82);
        step(1, 0, 0, 0, 8'h30, 8'h15, 8'h02, "R2 0x82 vs 0x02");
        check(flag_q, 8'h10, "R4 update only");
        rd_flags("R6 clear");
        step(1, 0, 0, 0, 8'h30, 8'h15, 8'h82, "R3 full match");
        check(flag_q, 8'h30, "R3 alarm flag");
        step(0, 0, 0, 0, 8'h31, 8'h15, 8'h82, "R3 sticky");
        rd_flags("R6 clear");
        wr_alarm(2'd2, 8'h02);
        step(1, 0, 0, 0, 8'h30, 8'h15, 8'h82, "R2 0x02 vs 0x82");
        step(1, 0, 0, 0, 8'h30, 8'h16, 8'h02, "R2 minute differs");
        rd_flags("R6 clear");

        // R9 select 3 ignored
        wr_alarm(2'd3, 8'h55);
        step(1, 0, 0, 0, 8'h30, 8'h15, 8'h02, "R9 sel3 ignored");
        check(flag_q, 8'h30, "R9 sel3 alarm kept");
        rd_flags("R6 clear");

        // R1 wildcards
        wr_alarm(2'd0, 8'hC0);
        wr_alarm(2'd1, 8'hFF);
        wr_alarm(2'd2, 8'hC7);
        step(1, 0, 0, 0, 8'h42, 8'h07, 8'h91, "R1 wildcard");
        check(flag_q, 8'h30, "R1 wildcard alarm");
        rd_flags("R6 clear");
        wr_alarm(2'd2, 8'h80);
        step(1, 0, 0, 0, 8'h42, 8'h07, 8'h91, "R1 one top bit not wild");

        // R8 hold
        rd_flags("R6 clear");
        step(1, 0, 0, 1, 8'h00, 8'h00, 8'h80, "R8 hold ignores update");
        check(flag_q, 8'h00, "R8 nothing set");

        // R5 periodic, R7 enables
        step(0, 1, 0, 0, 8'h00, 8'h00, 8'h80, "R5 periodic");
        check(flag_q, 8'h40, "R5 periodic flag");
        irq_en = 3'b010;
        step(0, 0, 0, 0, 8'h00, 8'h00, 8'h80, "R7 masked periodic");
        irq_en = 3'b100;
        step(0, 0, 0, 0, 8'h00, 8'h00, 8'h80, "R7 enabled periodic");
        check({7'd0, irq}, 8'h01, "R7 irq high");
        step(0, 1, 1, 0, 8'h00, 8'h00, 8'h80, "R6 read with event");
        check(flag_q, 8'hC0, "R6 event survives read");
        irq_en = 3'b011;
        rd_flags("R6 clear");
        step(1, 0, 0, 0, 8'h00, 8'h00, 8'h80, "R7 alarm enabled");
        check(flag_q, 8'hB0, "R7 alarm and update req");

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [7:0] t [3];
            int r;
            r = $urandom_range(0, 99);
            if (r < 12) begin
                int sel;
                logic [7:0] d;
                sel = $urandom_range(0, 3);
                d = $urandom_range(0, 255);
                if ($urandom_range(0, 3) == 0) d = d | 8'hC0;
                else d = d & 8'h7F | ($urandom_range(0, 1) ? 8'h80 : 8'h00);
                wr_alarm(2'(sel), d);
            end else begin
                irq_en = 3'($urandom_range(0, 7));
                for (int k = 0; k < 3; k++) begin
                    if ($urandom_range(0, 1) == 1 && m_alm[k][7:6] != 2'b11) t[k] = m_alm[k];
                    else t[k] = 8'($urandom_range(0, 255));
                    if ($urandom_range(0, 7) == 0) t[k] = t[k] ^ 8'h80;
                end
                step($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                     $urandom_range(0, 9) < 3, $urandom_range(0, 6) == 0,
                     t[0], t[1], t[2], "R1 R2 R3 R4 R5 R6 R7 R8 random");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule